// File: doc/BRIEF.md
# Set-Associative Data Cache

This block is a data cache placed between a processor's load/store port and a backing memory that moves whole lines. Its geometry is fixed at elaboration: the associativity, the number of sets and the words per line are each given as a base-two exponent. An associativity exponent of zero gives a direct-mapped cache. The write-hit policy is also a parameter, either write-back or write-through. Write misses always allocate the line.

A request is a single-cycle pulse on `cpu_req`, accepted while `cpu_ready` is high. The cache splits the byte address into tag, set, word-in-line and byte offset, and compares the tag against every way of the indexed set. A hit completes in the next cycle. A miss picks a victim. Invalid ways are used first; otherwise the way ranked least recently used is taken. A dirty victim is written back first, and then the line is fetched. Every way of a set holds a rank, and the ranks of a set always form a permutation of 0 to ways−1.

The memory side is a request/acknowledge port. `mem_req` stays high, with a stable address and direction, until `mem_ack` is seen for one cycle, and each handshake moves one full line.

Top module: `sa_dcache`

## Requirements
- R1: The byte address is split as byte offset, then word-in-line, then set, then tag, from the least significant bit up. With the default parameters these are bits 1:0, 3:2, 7:4 and 15:8. Accesses that differ only in the byte offset read the same word.
- R2: A hit raises `cpu_done` with `cpu_hit`=1 in the cycle after the request, except for a write hit under write-through. A miss raises `cpu_done` with `cpu_hit`=0 after the line fill. `cpu_rdata` carries the addressed word, and `cpu_done` is only high while `cpu_ready` is high.
- R3: All ways of the indexed set are compared, and at most one way matches. In a two-way build, two lines with the same set and different tags stay resident together.
- R4: Each way of a set carries a rank. A touched way gets rank 0, and every way ranked below its old rank moves up by one. When all ways are valid, the way ranked ways−1 is evicted. The ranks of a set are always distinct.
- R5: An invalid way of the set is filled before any valid way is evicted.
- R6: With write-back, a write hit only marks the line dirty and causes no memory write. When a dirty victim is evicted, its whole line is written to memory before the fill request.
- R7: A write miss fetches the line and merges the written word into it. Later reads of the other words return the memory contents.
- R8: With write-through, every completed write (hit or allocate) sends the updated line to memory before `cpu_done`. Lines are never dirty, so eviction writes nothing.
- R9: After synchronous reset every line is invalid, `cpu_ready` is 1, and `cpu_done` and `mem_req` are 0.
- R10: `mem_req` holds its address and direction stable until `mem_ack`. Each miss causes exactly one line fill, and the address is line-aligned.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | Access request pulse, taken when `cpu_ready` is high |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | ADDR_W | Byte address |
| cpu_wdata | input | DATA_W | Store data |
| cpu_ready | output | 1 | Cache idle and able to take a request |
| cpu_done | output | 1 | Access complete (one cycle) |
| cpu_hit | output | 1 | Completed access was a hit |
| cpu_rdata | output | DATA_W | Addressed word after the access |
| mem_req | output | 1 | Memory transfer request |
| mem_we | output | 1 | 1 = line write to memory, 0 = line fill |
| mem_addr | output | ADDR_W | Line-aligned byte address |
| mem_wdata | output | DATA_W*2^WORDS_LOG2 | Line written to memory |
| mem_rdata | input | DATA_W*2^WORDS_LOG2 | Line returned by a fill |
| mem_ack | input | 1 | Transfer complete (one cycle) |

## Verification
Two functions can land in one miss: the write-back of a dirty victim and the fill of the new line. The bench provokes this by dirtying a line with a store hit, then forcing its eviction through conflicting tags in the same set. It judges the result by the memory model's write and fill counts and by a later re-fetch that must return the stored value. In the write-through build, a write and the LRU update land together. The bench checks that the memory copy has changed before `cpu_done`, and that the line written last survives the next eviction.

// File: rtl/dc_pkg.sv
package dc_pkg;

    // Controller phases of the cache.
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_EVICT = 2'd1,
        ST_FILL  = 2'd2,
        ST_WTHRU = 2'd3
    } dc_state_e;

    // Width of a way index / rank; one bit minimum for the direct-mapped build.
    function automatic int unsigned rank_width(input int unsigned ways_log2);
        return (ways_log2 > 0) ? ways_log2 : 1;
    endfunction

endpackage

// File: rtl/dc_lookup.sv
module dc_lookup #(
    parameter int WAYS  = 2,
    parameter int TAG_W = 8,
    parameter int IW    = 1
) (
    input  logic [WAYS-1:0][TAG_W-1:0] way_tags,
    input  logic [WAYS-1:0]            way_valid,
    input  logic [TAG_W-1:0]           probe_tag,
    output logic [WAYS-1:0]            match_vec,
    output logic                       hit,
    output logic [IW-1:0]              hit_way
);

    // One comparator per way.
    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign match_vec[w] = way_valid[w] && (way_tags[w] == probe_tag);
    end

    assign hit = |match_vec;

    always_comb begin
        hit_way = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (match_vec[w]) hit_way = hit_way | IW'(w);
        end
    end

endmodule

// File: rtl/dc_lru.sv
module dc_lru #(
    parameter int WAYS_LOG2 = 1,
    parameter int SETS_LOG2 = 4
) (
    input  logic                                         clk,
    input  logic                                         rst,
    input  logic [SETS_LOG2-1:0]                         set_idx,
    input  logic [(1<<WAYS_LOG2)-1:0]                    way_valid,
    input  logic                                         touch,
    input  logic [dc_pkg::rank_width(WAYS_LOG2)-1:0]     touch_way,
    output logic [dc_pkg::rank_width(WAYS_LOG2)-1:0]     victim_way
);

    localparam int WAYS = 1 << WAYS_LOG2;
    localparam int SETS = 1 << SETS_LOG2;
    localparam int RW   = dc_pkg::rank_width(WAYS_LOG2);

    if (WAYS == 1) begin : g_direct
        logic unused_lru;
        assign unused_lru = ^{clk, rst, set_idx, way_valid, touch, touch_way};
        assign victim_way = '0;
    end else begin : g_ranked
        logic [RW-1:0] rank_q [SETS][WAYS];
        logic [RW-1:0] old_rank;
        logic          found;
        logic          perm_ok;
        logic          chk_touch_q;
        logic [SETS_LOG2-1:0] chk_set_q;
        logic [RW-1:0] chk_way_q;

        assign old_rank = rank_q[set_idx][touch_way];

        // Rank update: touched way to 0, younger ways age by one.
        always_ff @(posedge clk) begin
            if (rst) begin
                for (int s = 0; s < SETS; s++) begin
                    for (int w = 0; w < WAYS; w++) begin
                        rank_q[s][w] <= RW'(w);
                    end
                end
            end else if (touch) begin
                for (int w = 0; w < WAYS; w++) begin
                    if (RW'(w) == touch_way)
                        rank_q[set_idx][w] <= '0;
                    else if (rank_q[set_idx][w] < old_rank)
                        rank_q[set_idx][w] <= rank_q[set_idx][w] + RW'(1);
                end
            end
        end

        // Victim: lowest invalid way, else the oldest rank.
        always_comb begin
            victim_way = '0;
            found      = 1'b0;
            for (int w = 0; w < WAYS; w++) begin
                if (!found && !way_valid[w]) begin
                    victim_way = RW'(w);
                    found      = 1'b1;
                end
            end
            if (!found) begin
                for (int w = 0; w < WAYS; w++) begin
                    if (rank_q[set_idx][w] == RW'(WAYS - 1)) victim_way = RW'(w);
                end
            end
        end

        always_comb begin
            int cnt;
            perm_ok = 1'b1;
            for (int k = 0; k < WAYS; k++) begin
                cnt = 0;
                for (int w = 0; w < WAYS; w++) begin
                    if (rank_q[set_idx][w] == RW'(k)) cnt++;
                end
                if (cnt != 1) perm_ok = 1'b0;
            end
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                chk_touch_q <= 1'b0;
                chk_set_q   <= '0;
                chk_way_q   <= '0;
            end else begin
                chk_touch_q <= touch;
                chk_set_q   <= set_idx;
                chk_way_q   <= touch_way;
            end
        end

        AST_RANK_PERM: assert property (@(posedge clk) disable iff (rst)
            perm_ok);                                                    // R4
        AST_TOUCH_MRU: assert property (@(posedge clk) disable iff (rst)
            chk_touch_q |-> (rank_q[chk_set_q][chk_way_q] == '0));       // R4
    end

endmodule

// File: rtl/sa_dcache.sv
module sa_dcache #(
    parameter int ADDR_W     = 16,
    parameter int DATA_W     = 32,
    parameter int WAYS_LOG2  = 1,
    parameter int SETS_LOG2  = 4,
    parameter int WORDS_LOG2 = 2,
    parameter bit WRITE_BACK = 1'b1
) (
    input  logic                                clk,
    input  logic                                rst,
    input  logic                                cpu_req,
    input  logic                                cpu_we,
    input  logic [ADDR_W-1:0]                   cpu_addr,
    input  logic [DATA_W-1:0]                   cpu_wdata,
    output logic                                cpu_ready,
    output logic                                cpu_done,
    output logic                                cpu_hit,
    output logic [DATA_W-1:0]                   cpu_rdata,
    output logic                                mem_req,
    output logic                                mem_we,
    output logic [ADDR_W-1:0]                   mem_addr,
    output logic [DATA_W*(1<<WORDS_LOG2)-1:0]   mem_wdata,
    input  logic [DATA_W*(1<<WORDS_LOG2)-1:0]   mem_rdata,
    input  logic                                mem_ack
);
    import dc_pkg::*;

    localparam int WAYS   = 1 << WAYS_LOG2;
    localparam int SETS   = 1 << SETS_LOG2;
    localparam int WORDS  = 1 << WORDS_LOG2;
    localparam int OFF_W  = $clog2(DATA_W / 8);
    localparam int LOW_W  = WORDS_LOG2 + OFF_W;
    localparam int TAG_W  = ADDR_W - SETS_LOG2 - LOW_W;
    localparam int LINE_W = DATA_W * WORDS;
    localparam int IW     = rank_width(WAYS_LOG2);

    typedef struct packed {
        logic                  we;
        logic [TAG_W-1:0]      tag;
        logic [SETS_LOG2-1:0]  set;
        logic [WORDS_LOG2-1:0] word;
        logic [DATA_W-1:0]     wdata;
    } req_t;

    // Storage
    logic [WAYS-1:0][TAG_W-1:0]  tag_q   [SETS];
    logic [WAYS-1:0]             valid_q [SETS];
    logic [WAYS-1:0]             dirty_q [SETS];
    logic [WAYS-1:0][LINE_W-1:0] data_q  [SETS];

    dc_state_e   state_q;
    req_t        rq_q;
    req_t        probe;
    logic [IW-1:0]     act_way_q;
    logic              done_q;
    logic              hit_q;
    logic [DATA_W-1:0] rdata_q;

    // Address fields of the incoming request
    logic unused_bits;
    assign unused_bits = ^cpu_addr[OFF_W-1:0];

    always_comb begin
        probe.we    = cpu_we;
        probe.tag   = cpu_addr[ADDR_W-1 -: TAG_W];
        probe.set   = cpu_addr[LOW_W +: SETS_LOG2];
        probe.word  = cpu_addr[OFF_W +: WORDS_LOG2];
        probe.wdata = cpu_wdata;
    end

    // Lookup uses the live request when idle, the latched one otherwise.
    req_t look;
    assign look = (state_q == ST_IDLE) ? probe : rq_q;

    logic [WAYS-1:0] match_vec;
    logic            hit;
    logic [IW-1:0]   hit_way;
    logic [IW-1:0]   victim;
    logic            touch;
    logic [IW-1:0]   touch_way;

    dc_lookup #(
        .WAYS  (WAYS),
        .TAG_W (TAG_W),
        .IW    (IW)
    ) u_lookup (
        .way_tags  (tag_q[look.set]),
        .way_valid (valid_q[look.set]),
        .probe_tag (look.tag),
        .match_vec (match_vec),
        .hit       (hit),
        .hit_way   (hit_way)
    );

    assign touch     = ((state_q == ST_IDLE) && cpu_req && hit) ||
                       ((state_q == ST_FILL) && mem_ack);
    assign touch_way = (state_q == ST_IDLE) ? hit_way : act_way_q;

    dc_lru #(
        .WAYS_LOG2 (WAYS_LOG2),
        .SETS_LOG2 (SETS_LOG2)
    ) u_lru (
        .clk        (clk),
        .rst        (rst),
        .set_idx    (look.set),
        .way_valid  (valid_q[look.set]),
        .touch      (touch),
        .touch_way  (touch_way),
        .victim_way (victim)
    );

    // Line merges
    logic [LINE_W-1:0] hit_line;
    logic [LINE_W-1:0] fill_line;

    always_comb begin
        hit_line = data_q[look.set][hit_way];
        if (probe.we) hit_line[probe.word*DATA_W +: DATA_W] = probe.wdata;
        fill_line = mem_rdata;
        if (rq_q.we) fill_line[rq_q.word*DATA_W +: DATA_W] = rq_q.wdata;
    end

    logic victim_dirty;
    assign victim_dirty = WRITE_BACK && valid_q[probe.set][victim] && dirty_q[probe.set][victim];

    // Controller
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_IDLE;
            rq_q      <= '0;
            act_way_q <= '0;
            done_q    <= 1'b0;
            hit_q     <= 1'b0;
            rdata_q   <= '0;
            for (int s = 0; s < SETS; s++) begin
                tag_q[s]   <= '0;
                valid_q[s] <= '0;
                dirty_q[s] <= '0;
                data_q[s]  <= '0;
            end
        end else begin
            done_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (cpu_req) begin
                        rq_q  <= probe;
                        hit_q <= hit;
                        if (hit) begin
                            act_way_q <= hit_way;
                            rdata_q   <= hit_line[probe.word*DATA_W +: DATA_W];
                            if (probe.we) begin
                                data_q[probe.set][hit_way] <= hit_line;
                                if (WRITE_BACK) dirty_q[probe.set][hit_way] <= 1'b1;
                            end
                            if (probe.we && !WRITE_BACK) state_q <= ST_WTHRU;
                            else                         done_q  <= 1'b1;
                        end else begin
                            act_way_q <= victim;
                            state_q   <= victim_dirty ? ST_EVICT : ST_FILL;
                        end
                    end
                end
                ST_EVICT: begin
                    if (mem_ack) begin
                        dirty_q[rq_q.set][act_way_q] <= 1'b0;
                        state_q <= ST_FILL;
                    end
                end
                ST_FILL: begin
                    if (mem_ack) begin
                        data_q[rq_q.set][act_way_q]  <= fill_line;
                        tag_q[rq_q.set][act_way_q]   <= rq_q.tag;
                        valid_q[rq_q.set][act_way_q] <= 1'b1;
                        dirty_q[rq_q.set][act_way_q] <= WRITE_BACK && rq_q.we;
                        rdata_q <= fill_line[rq_q.word*DATA_W +: DATA_W];
                        if (rq_q.we && !WRITE_BACK) begin
                            state_q <= ST_WTHRU;
                        end else begin
                            state_q <= ST_IDLE;
                            done_q  <= 1'b1;
                        end
                    end
                end
                ST_WTHRU: begin
                    if (mem_ack) begin
                        state_q <= ST_IDLE;
                        done_q  <= 1'b1;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Memory port
    always_comb begin
        mem_req   = (state_q != ST_IDLE);
        mem_we    = (state_q == ST_EVICT) || (state_q == ST_WTHRU);
        mem_addr  = {rq_q.tag, rq_q.set, {LOW_W{1'b0}}};
        mem_wdata = '0;
        if (state_q == ST_EVICT) begin
            mem_addr  = {tag_q[rq_q.set][act_way_q], rq_q.set, {LOW_W{1'b0}}};
            mem_wdata = data_q[rq_q.set][act_way_q];
        end else if (state_q == ST_WTHRU) begin
            mem_wdata = data_q[rq_q.set][act_way_q];
        end
    end

    assign cpu_ready = (state_q == ST_IDLE);
    assign cpu_done  = done_q;
    assign cpu_hit   = hit_q;
    assign cpu_rdata = rdata_q;

    // Checks
    AST_ONE_MATCH: assert property (@(posedge clk) disable iff (rst)
        $onehot0(match_vec));                                                   // R3
    AST_HIT_NEXT: assert property (@(posedge clk) disable iff (rst)
        (cpu_req && cpu_ready && hit && (WRITE_BACK || !cpu_we)) |=> (cpu_done && cpu_hit)); // R2
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
        cpu_done |-> cpu_ready);                                                // R2
    AST_MEM_HOLD: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we))); // R10
    AST_EVICT_FILL: assert property (@(posedge clk) disable iff (rst)
        ((state_q == ST_EVICT) && mem_ack) |=> (mem_req && !mem_we));           // R6
    AST_WT_CLEAN: assert property (@(posedge clk) disable iff (rst)
        (!WRITE_BACK) |-> (dirty_q[look.set] == '0));                           // R8

endmodule

// File: tb/sim_sa_dcache.sv
module sim_mem #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32,
    parameter int WORDS  = 4
) (
    input  logic                      clk,
    input  logic                      req,
    input  logic                      we,
    input  logic [ADDR_W-1:0]         addr,
    input  logic [DATA_W*WORDS-1:0]   wdata,
    output logic [DATA_W*WORDS-1:0]   rdata,
    output logic                      ack
);
    int n_fill;
    int n_wr;
    logic [DATA_W-1:0] store [int];

    function automatic logic [DATA_W-1:0] peek(input int a);
        if (store.exists(a)) return store[a];
        return DATA_W'(32'h5A00_0000 + a);
    endfunction

    initial begin
        ack = 1'b0; rdata = '0; n_fill = 0; n_wr = 0;
        forever begin
            @(negedge clk);
            if (ack) begin
                ack = 1'b0;
            end else if (req) begin
                if (we) begin
                    for (int i = 0; i < WORDS; i++) store[int'(addr) + 4*i] = wdata[i*DATA_W +: DATA_W];
                    n_wr++;
                end else begin
                    for (int i = 0; i < WORDS; i++) rdata[i*DATA_W +: DATA_W] = peek(int'(addr) + 4*i);
                    n_fill++;
                end
                ack = 1'b1;
            end
        end
    end
endmodule

module sim_sa_dcache;
    localparam int AW = 16;
    localparam int DW = 32;
    localparam int LW = DW * 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    logic          req0 = 0, we0 = 0, req1 = 0, we1 = 0;
    logic [AW-1:0] addr0 = '0, addr1 = '0;
    logic [DW-1:0] wd0 = '0, wd1 = '0;
    logic ready0, done0, hit0, ready1, done1, hit1;
    logic [DW-1:0] rd0, rd1;
    logic mreq0, mwe0, mack0, mreq1, mwe1, mack1;
    logic [AW-1:0] maddr0, maddr1;
    logic [LW-1:0] mwd0, mrd0, mwd1, mrd1;

    sa_dcache #(.WRITE_BACK(1'b1)) u0 (
        .clk(clk), .rst(rst), .cpu_req(req0), .cpu_we(we0), .cpu_addr(addr0), .cpu_wdata(wd0),
        .cpu_ready(ready0), .cpu_done(done0), .cpu_hit(hit0), .cpu_rdata(rd0),
        .mem_req(mreq0), .mem_we(mwe0), .mem_addr(maddr0), .mem_wdata(mwd0),
        .mem_rdata(mrd0), .mem_ack(mack0));
    sim_mem m0 (.clk(clk), .req(mreq0), .we(mwe0), .addr(maddr0), .wdata(mwd0), .rdata(mrd0), .ack(mack0));

    sa_dcache #(.WRITE_BACK(1'b0)) u1 (
        .clk(clk), .rst(rst), .cpu_req(req1), .cpu_we(we1), .cpu_addr(addr1), .cpu_wdata(wd1),
        .cpu_ready(ready1), .cpu_done(done1), .cpu_hit(hit1), .cpu_rdata(rd1),
        .mem_req(mreq1), .mem_we(mwe1), .mem_addr(maddr1), .mem_wdata(mwd1),
        .mem_rdata(mrd1), .mem_ack(mack1));
    sim_mem m1 (.clk(clk), .req(mreq1), .we(mwe1), .addr(maddr1), .wdata(mwd1), .rdata(mrd1), .ack(mack1));

    int n_chk = 0;
    int n_bad = 0;

    task automatic check(input bit ok, input int rq, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL R%0d %s: actual %h expected %h", rq, what, act, exp);
        end
    endtask

    task automatic access(input int dut, input logic we, input logic [AW-1:0] a, input logic [DW-1:0] d,
                          output logic h, output logic [DW-1:0] r, output int lat);
        @(negedge clk);
        if (dut == 0) begin req0 = 1; we0 = we; addr0 = a; wd0 = d; end
        else          begin req1 = 1; we1 = we; addr1 = a; wd1 = d; end
        @(negedge clk);
        req0 = 0; req1 = 0;
        lat = 1;
        while (!((dut == 0) ? done0 : done1) && lat < 200) begin
            @(negedge clk);
            lat++;
        end
        h = (dut == 0) ? hit0 : hit1;
        r = (dut == 0) ? rd0 : rd1;
    endtask

    typedef struct packed {
        logic        we;
        logic [15:0] addr;
        logic [31:0] wdata;
        logic        exp_hit;
        logic        chk_data;
        logic [31:0] exp_data;
        logic [7:0]  exp_fill;
        logic [7:0]  exp_wb;
        logic [7:0]  rq;
    } vec_t;

    // Write-back build; set 0 holds tags 0x10/0x12/0x14, set 3 tag 0x20.
    localparam vec_t VECS [15] = '{
        '{1'b0, 16'h1000, 32'h0,        1'b0, 1'b1, 32'h5A001000, 8'd1, 8'd0, 8'd9},  // R9 cold miss
        '{1'b0, 16'h1004, 32'h0,        1'b1, 1'b1, 32'h5A001004, 8'd1, 8'd0, 8'd1},  // R1 word select
        '{1'b0, 16'h1203, 32'h0,        1'b0, 1'b1, 32'h5A001200, 8'd2, 8'd0, 8'd5},  // R5 invalid way used
        '{1'b0, 16'h1008, 32'h0,        1'b1, 1'b1, 32'h5A001008, 8'd2, 8'd0, 8'd3},  // R3 coexist
        '{1'b0, 16'h120C, 32'h0,        1'b1, 1'b1, 32'h5A00120C, 8'd2, 8'd0, 8'd3},  // R3 coexist
        '{1'b1, 16'h1004, 32'h11111111, 1'b1, 1'b0, 32'h0,        8'd2, 8'd0, 8'd6},  // R6 no write
        '{1'b0, 16'h1004, 32'h0,        1'b1, 1'b1, 32'h11111111, 8'd2, 8'd0, 8'd2},  // R2 hit data
        '{1'b0, 16'h1400, 32'h0,        1'b0, 1'b1, 32'h5A001400, 8'd3, 8'd0, 8'd4},  // R4 evict oldest
        '{1'b0, 16'h1000, 32'h0,        1'b1, 1'b1, 32'h5A001000, 8'd3, 8'd0, 8'd4},  // R4 young kept
        '{1'b0, 16'h1200, 32'h0,        1'b0, 1'b1, 32'h5A001200, 8'd4, 8'd0, 8'd4},  // R4 evicted earlier
        '{1'b0, 16'h1400, 32'h0,        1'b0, 1'b1, 32'h5A001400, 8'd5, 8'd1, 8'd6},  // R6 dirty writeback
        '{1'b0, 16'h1004, 32'h0,        1'b0, 1'b1, 32'h11111111, 8'd6, 8'd1, 8'd6},  // R6 data survived
        '{1'b1, 16'h2038, 32'h22222222, 1'b0, 1'b0, 32'h0,        8'd7, 8'd1, 8'd7},  // R7 allocate
        '{1'b0, 16'h2038, 32'h0,        1'b1, 1'b1, 32'h22222222, 8'd7, 8'd1, 8'd7},  // R7 merged word
        '{1'b0, 16'h2034, 32'h0,        1'b1, 1'b1, 32'h5A002034, 8'd7, 8'd1, 8'd7}   // R7 rest of line
    };

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL R2 watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic h;
        logic [DW-1:0] r;
        int lat;
        repeat (4) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R9 reset state
        check(ready0 == 1'b1, 9, "ready after reset", 32'(ready0), 32'd1);
        check(done0 == 1'b0, 9, "done after reset", 32'(done0), 32'd0);
        check(mreq0 == 1'b0, 9, "mem_req after reset", 32'(mreq0), 32'd0);

        for (int i = 0; i < 15; i++) begin
            access(0, VECS[i].we, VECS[i].addr, VECS[i].wdata, h, r, lat);
            check(h == VECS[i].exp_hit, int'(VECS[i].rq), $sformatf("vec %0d hit", i), 32'(h), 32'(VECS[i].exp_hit));
            if (VECS[i].chk_data)
                check(r == VECS[i].exp_data, int'(VECS[i].rq), $sformatf("vec %0d data", i), r, VECS[i].exp_data);
            if (VECS[i].exp_hit)   // R2 hit completes next cycle
                check(lat == 1, 2, $sformatf("vec %0d hit latency", i), 32'(lat), 32'd1);
            check(m0.n_fill == int'(VECS[i].exp_fill), 10, $sformatf("vec %0d fills", i),   // R10
                  32'(m0.n_fill), 32'(VECS[i].exp_fill));
            check(m0.n_wr == int'(VECS[i].exp_wb), int'(VECS[i].rq) == 6 ? 6 : 10,
                  $sformatf("vec %0d writebacks", i), 32'(m0.n_wr), 32'(VECS[i].exp_wb));
        end
        // R1 byte offset ignored within a word
        access(0, 1'b0, 16'h2037, '0, h, r, lat);
        check(r == 32'h5A002034, 1, "byte offset ignored", r, 32'h5A002034);

        // R8 write-through build
        access(1, 1'b0, 16'h1000, '0, h, r, lat);
        check(h == 1'b0, 8, "wt cold miss", 32'(h), 32'd0);
        access(1, 1'b1, 16'h1000, 32'h33333333, h, r, lat);
        check(h == 1'b1, 8, "wt write hit", 32'(h), 32'd1);
        check(m1.n_wr == 1, 8, "wt write count", 32'(m1.n_wr), 32'd1);
        check(m1.peek(32'h1000) == 32'h33333333, 8, "wt memory word", m1.peek(32'h1000), 32'h33333333);
        access(1, 1'b0, 16'h1000, '0, h, r, lat);
        check(r == 32'h33333333, 8, "wt read back", r, 32'h33333333);
        access(1, 1'b1, 16'h3000, 32'h44444444, h, r, lat);
        check(h == 1'b0, 7, "wt write miss", 32'(h), 32'd0);
        check(m1.n_fill == 2 && m1.n_wr == 2, 8, "wt allocate traffic", 32'(m1.n_wr), 32'd2);
        check(m1.peek(32'h3000) == 32'h44444444, 8, "wt allocate word", m1.peek(32'h3000), 32'h44444444);
        access(1, 1'b0, 16'h1200, '0, h, r, lat);
        check(m1.n_wr == 2, 8, "wt eviction writes nothing", 32'(m1.n_wr), 32'd2);
        access(1, 1'b0, 16'h3000, '0, h, r, lat);
        check(h == 1'b1 && r == 32'h44444444, 4, "wt newest line kept", r, 32'h44444444);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule